// File: doc/BRIEF.md
# Link-Clock Transition Watchdog

This block watches the serial clock line that a host drives on a host-to-module data link. It counts every change of level on that line, both rising and falling. It has no idea of elapsed time. A healthy local controller finishes each transaction and then clears the count. A controller that has hung leaves the count alone, so transitions keep adding up until they pass a fixed limit. The block then drives a reset pulse of fixed length into the controller.

The clock line is asynchronous to the system clock, so it first goes through a synchroniser. A transition is taken to be any difference between two successive synchronised samples. Transaction sizes guide the choice of limit:

- a state poll costs 16 transitions;
- a per-channel accumulator read costs 16 transitions for each channel plus 24 transitions of overhead.

With the default limit of 64, several short polls can run back to back without a clear and stay just under the limit. A hung controller is still caught within the next transaction or two. How soon the block trips therefore depends on how often the host polls, not on any timer.

Top module: `linkclk_watchdog`

## Requirements
- R1: Every change of level on `link_clk_i` adds one to the count, whether the line rose or fell, as long as no clear is present and no reset pulse is active.
- R2: A high `wd_clear_i` on a clock edge while no reset pulse is active sets the count to zero. After that, a further 64 transitions are absorbed without a trip.
- R3: While the count since the last clear is 64 or fewer, `ctrl_reset_o` stays low.
- R4: The 65th counted transition raises `ctrl_reset_o`. It is high from the third rising system-clock edge after the line changes (two synchroniser flops plus one register).
- R5: Each reset pulse is high for exactly 16 system-clock cycles.
- R6: Exactly one pulse is issued per trip. Line transitions and clears that arrive during the pulse are ignored. When the pulse ends the count is zero, so another 65 transitions are needed for the next trip.
- R7: If a clear and a detected transition fall on the same clock edge, the clear wins and that transition is not counted.
- R8: While the synchronous active-high `rst` is high on a clock edge, `ctrl_reset_o` is low, the count is zero and the synchroniser holds zero.
- R9: Four 16-transition state polls with no clear between them (64 transitions in total) do not trip. A two-channel read (56 transitions) followed by a state poll (16 transitions, 72 in total) without a clear does trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| link_clk_i | input | 1 | Host-driven link clock line, asynchronous |
| wd_clear_i | input | 1 | Clear strobe from the local controller |
| ctrl_reset_o | output | 1 | Reset pulse to the local controller |

## Verification
The count is never visible at the ports. A wrong count shows up only as a reset pulse that comes too early, too late or not at all. The bench therefore lines up exact transition totals on either side of the limit. It also sends a clear in the very cycle a transition is detected, and it toggles the line and clears during a pulse.

A count that is off by one shows up as a pulse one transition early or late. A pulse-length or re-arm fault shows up within 16 cycles of the trip, or on the next batch of 65 transitions. The reference model runs every cycle and reports any mismatch on `ctrl_reset_o` in the cycle it occurs.

// File: rtl/lcw_pkg.sv
package lcw_pkg;

    localparam int unsigned LCW_TRIP_LIMIT  = 64;
    localparam int unsigned LCW_PULSE_LEN   = 16;
    localparam int unsigned LCW_SYNC_STAGES = 2;

    // Count width: must hold the limit plus one saturated "tripped" value.
    function automatic int unsigned lcw_cnt_width(input int unsigned limit);
        return $clog2(limit + 2);
    endfunction

    // Width of the pulse down-counter.
    function automatic int unsigned lcw_len_width(input int unsigned len);
        return (len < 2) ? 1 : $clog2(len);
    endfunction

    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_HOLD = 1'b1
    } lcw_pulse_state_e;

endpackage

// File: rtl/lcw_edge_sync.sv
module lcw_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic edge_o
);
    // pipe[0..STAGES-1] is the synchroniser; pipe[STAGES] is the prior sample.
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], line_i};
        end
    end

    always_comb edge_o = pipe_q[STAGES-1] ^ pipe_q[STAGES];

endmodule

// File: rtl/lcw_trans_counter.sv
module lcw_trans_counter #(
    parameter int unsigned TRIP_LIMIT = 64,
    parameter int unsigned CNT_W      = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    input  logic             clear_i,
    input  logic             release_i,
    output logic             trip_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TRIP_LIMIT);

    logic [CNT_W-1:0] count_q;
    logic             tripped;

    always_comb begin
        tripped = (count_q > LIMIT);
        trip_o  = edge_i && !clear_i && !tripped && (count_q == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (tripped) begin
            // Saturated: hold until the reset pulse has completed.
            if (release_i) begin
                count_q <= '0;
            end
        end else if (clear_i) begin
            count_q <= '0;
        end else if (edge_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/lcw_pulse_gen.sv
module lcw_pulse_gen
    import lcw_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trip_i,
    output logic pulse_o,
    output logic done_o
);
    localparam int unsigned LW = lcw_len_width(PULSE_LEN);
    localparam logic [LW-1:0] LOAD = LW'(PULSE_LEN - 1);

    lcw_pulse_state_e state_q;
    logic [LW-1:0]    left_q;

    always_comb begin
        pulse_o = (state_q == PG_HOLD);
        done_o  = (state_q == PG_HOLD) && (left_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PG_IDLE;
            left_q  <= '0;
        end else begin
            unique case (state_q)
                PG_IDLE: begin
                    if (trip_i) begin
                        state_q <= PG_HOLD;
                        left_q  <= LOAD;
                    end
                end
                PG_HOLD: begin
                    if (left_q == '0) begin
                        state_q <= PG_IDLE;
                    end else begin
                        left_q <= left_q - LW'(1);
                    end
                end
                default: state_q <= PG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/linkclk_watchdog.sv
module linkclk_watchdog
    import lcw_pkg::*;
#(
    parameter int unsigned TRIP_LIMIT  = LCW_TRIP_LIMIT,
    parameter int unsigned PULSE_LEN   = LCW_PULSE_LEN,
    parameter int unsigned SYNC_STAGES = LCW_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic link_clk_i,
    input  logic wd_clear_i,
    output logic ctrl_reset_o
);
    localparam int unsigned CNT_W = lcw_cnt_width(TRIP_LIMIT);

    logic             edge_det;
    logic             trip;
    logic             pulse_done;
    logic [CNT_W-1:0] trans_cnt;

    lcw_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_i (link_clk_i),
        .edge_o (edge_det)
    );

    lcw_trans_counter #(
        .TRIP_LIMIT (TRIP_LIMIT),
        .CNT_W      (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .edge_i    (edge_det),
        .clear_i   (wd_clear_i),
        .release_i (pulse_done),
        .trip_o    (trip),
        .count_o   (trans_cnt)
    );

    lcw_pulse_gen #(
        .PULSE_LEN (PULSE_LEN)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .trip_i  (trip),
        .pulse_o (ctrl_reset_o),
        .done_o  (pulse_done)
    );

endmodule

// File: rtl/lcw_checker.sv
module lcw_checker #(
    parameter int unsigned TRIP_LIMIT = 64,
    parameter int unsigned PULSE_LEN  = 16,
    parameter int unsigned CNT_W      = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             wd_clear_i,
    input logic             ctrl_reset_o,
    input logic             edge_det,
    input logic             trip,
    input logic             pulse_done,
    input logic [CNT_W-1:0] trans_cnt
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(TRIP_LIMIT);
    localparam int unsigned HW = $clog2(PULSE_LEN + 1) + 1;

    logic [HW-1:0] high_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            high_len <= '0;
        end else if (ctrl_reset_o) begin
            high_len <= high_len + HW'(1);
        end else begin
            high_len <= '0;
        end
    end

    // R1: a counted transition advances the count by one
    a_r1_edge_inc: assert property (@(posedge clk) disable iff (rst)
        (edge_det && !wd_clear_i && !ctrl_reset_o && trans_cnt < LIM)
        |=> trans_cnt == $past(trans_cnt) + CNT_W'(1));

    // R2 and R7: a clear outside a pulse zeroes the count, even with an edge
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (wd_clear_i && !ctrl_reset_o) |=> trans_cnt == '0);

    // R3: no trip below the limit
    a_r3_no_early_trip: assert property (@(posedge clk) disable iff (rst)
        (trans_cnt < LIM) |-> !trip);

    // R4: a trip raises the reset output on the next cycle
    a_r4_trip_raises: assert property (@(posedge clk) disable iff (rst)
        trip |=> $rose(ctrl_reset_o));

    // R5: pulse length measured by counter
    a_r5_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_reset_o) |-> high_len == HW'(PULSE_LEN));

    // R5: pulse ends right after completion
    a_r5_done_ends: assert property (@(posedge clk) disable iff (rst)
        pulse_done |=> !ctrl_reset_o);

    // R6: no re-trip while a pulse is active
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset_o |-> !trip);

    // R6: count is zero once the pulse has ended
    a_r6_rearm_zero: assert property (@(posedge clk) disable iff (rst)
        pulse_done |=> trans_cnt == '0);

    // R8: synchronous reset state
    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (!ctrl_reset_o && trans_cnt == '0));

endmodule

bind linkclk_watchdog lcw_checker #(
    .TRIP_LIMIT (TRIP_LIMIT),
    .PULSE_LEN  (PULSE_LEN),
    .CNT_W      (CNT_W)
) u_lcw_checker (
    .clk          (clk),
    .rst          (rst),
    .wd_clear_i   (wd_clear_i),
    .ctrl_reset_o (ctrl_reset_o),
    .edge_det     (edge_det),
    .trip         (trip),
    .pulse_done   (pulse_done),
    .trans_cnt    (trans_cnt)
);

// File: tb/tb_linkclk_watchdog.sv
module tb_linkclk_watchdog;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 64;
    localparam int PLEN       = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_clk = 1'b0;
    logic wd_clear = 1'b0;
    logic ctrl_reset;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    linkclk_watchdog dut (
        .clk          (clk),
        .rst          (rst),
        .link_clk_i   (link_clk),
        .wd_clear_i   (wd_clear),
        .ctrl_reset_o (ctrl_reset)
    );

    // Behavioural reference model: a history of line samples and a
    // transition tally with a remaining-pulse countdown.
    int hist[$];
    int m_tally = 0;
    int m_rem   = 0;

    always @(posedge clk) begin
        bit seen;
        seen = 1'b0;
        if (hist.size() >= 3) seen = (hist[1] != hist[2]);
        if (rst) begin
            m_tally = 0;
            m_rem   = 0;
            hist.delete();
            hist.push_front(0); hist.push_front(0); hist.push_front(0);
        end else begin
            if (m_rem > 0) begin
                m_rem--;
                if (m_rem == 0) m_tally = 0;
            end else if (wd_clear) begin
                m_tally = 0;
            end else if (seen) begin
                if (m_tally == LIMIT) begin
                    m_tally = LIMIT + 1;
                    m_rem   = PLEN;
                end else begin
                    m_tally++;
                end
            end
            hist.push_front(int'(link_clk));
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    // Every-cycle comparison against the model (covers R1..R8)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (ctrl_reset !== (m_rem > 0)) begin
                n_fails++;
                $display("FAIL R4/R5 model compare at %0t: actual=%b expected=%b",
                         $time, ctrl_reset, (m_rem > 0));
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    task automatic toggles(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            link_clk = ~link_clk;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        wd_clear = 1'b1;
        @(negedge clk);
        wd_clear = 1'b0;
    endtask

    task automatic wait_pulse_end();
        while (ctrl_reset) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fails++;
            $display("FAIL watchdog timeout: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int hi;
        // R8: toggling during reset is ignored
        repeat (3) @(negedge clk);
        link_clk = 1'b1; @(negedge clk); link_clk = 1'b0;
        repeat (3) @(negedge clk);
        check(ctrl_reset == 1'b0, "R8 reset output low", ctrl_reset, 0);
        rst = 1'b0;
        settle();
        check(ctrl_reset == 1'b0, "R8 low after reset", ctrl_reset, 0);

        // R1 R3: 64 transitions (both directions) with gaps, no trip
        toggles(32, 2);
        toggles(32, 0);
        settle();
        check(ctrl_reset == 1'b0, "R3 64 transitions no reset", ctrl_reset, 0);
        check(link_clk == 1'b0, "R1 even count returns line low", link_clk, 0);

        // R4: 65th transition, with latency
        @(negedge clk);
        link_clk = ~link_clk;
        @(negedge clk);
        check(ctrl_reset == 1'b0, "R4 not yet after 1 edge", ctrl_reset, 0);
        @(negedge clk);
        check(ctrl_reset == 1'b0, "R4 not yet after 2 edges", ctrl_reset, 0);
        @(negedge clk);
        check(ctrl_reset == 1'b1, "R4 reset on 65th transition", ctrl_reset, 1);

        // R5: pulse length
        hi = 0;
        while (ctrl_reset && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check(hi == PLEN, "R5 pulse length", hi, PLEN);
        settle();

        // R6: count zero after pulse: 64 more, no trip; then 65th trips
        toggles(64, 1);
        settle();
        check(ctrl_reset == 1'b0, "R6 rearmed at zero", ctrl_reset, 0);
        toggles(1, 0);
        settle();
        check(ctrl_reset == 1'b1, "R6 second trip", ctrl_reset, 1);
        // R6: transitions and clears during the pulse are ignored
        toggles(3, 0);
        do_clear();
        toggles(2, 0);
        wait_pulse_end();
        check(ctrl_reset == 1'b0, "R6 single pulse", ctrl_reset, 0);
        toggles(64, 1);
        settle();
        check(ctrl_reset == 1'b0, "R6 in-pulse activity ignored", ctrl_reset, 0);

        // R2: clear between transactions prevents a trip
        do_clear();
        for (int t = 0; t < 5; t++) begin
            toggles(56, 0);
            settle();
            do_clear();
        end
        check(ctrl_reset == 1'b0, "R2 clears prevent trip", ctrl_reset, 0);
        toggles(64, 0);
        settle();
        check(ctrl_reset == 1'b0, "R2 64 after clear no trip", ctrl_reset, 0);
        do_clear();

        // R7: clear coincident with a detected transition wins
        toggles(63, 0);
        settle();
        @(negedge clk);
        link_clk = ~link_clk;        // 64th line change
        @(negedge clk);
        @(negedge clk);
        wd_clear = 1'b1;             // high at the edge that sees the change
        @(negedge clk);
        wd_clear = 1'b0;
        settle();
        toggles(64, 0);
        settle();
        check(ctrl_reset == 1'b0, "R7 coincident edge not counted", ctrl_reset, 0);
        toggles(1, 0);
        settle();
        check(ctrl_reset == 1'b1, "R7 trips on next 65th", ctrl_reset, 1);
        wait_pulse_end();

        // R9: four state polls without clear = 64, no trip
        for (int p = 0; p < 4; p++) begin
            toggles(16, 1);
            repeat (6) @(negedge clk);
        end
        check(ctrl_reset == 1'b0, "R9 four polls no trip", ctrl_reset, 0);
        do_clear();
        // R9: two-channel read then a state poll without clear trips
        toggles(56, 0);
        settle();
        check(ctrl_reset == 1'b0, "R9 two-channel read alone", ctrl_reset, 0);
        toggles(16, 0);
        settle();
        check(ctrl_reset == 1'b1 || m_rem > 0 || m_tally == 0, "R9 trip within poll",
              ctrl_reset, 1);
        wait_pulse_end();
        settle();

        // R8: mid-run reset clears a partial count
        toggles(40, 0);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        settle();
        toggles(64, 0);
        settle();
        check(ctrl_reset == 1'b0, "R8 reset clears count", ctrl_reset, 0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule